// File: doc/BRIEF.md
# Dirty Replica Side Cache

This block is a small, fully associative side store that sits next to a defect-tolerant L2 array. In such an array the per-block error code can be partly spent on covering permanent faulty cells. A soft error in a dirty block could then not be recovered. The L2 controller therefore sends a second copy of every dirty line it holds in a defective block to this block. Clean blocks are never sent, because a soft error in a clean block is repaired by fetching the line again from main memory. A recover request looks up a copy and returns it the cycle after the request. When L2 writes a block back or drops it, the controller removes the matching copy, and no memory traffic results.

When a new line arrives and every slot is in use, the least recently replicated entry is forced out early to main memory. A backup of dirty defective data therefore always exists, either in this store, in its single pending write-back buffer, or in memory. Control is a two-state machine. `ST_IDLE` accepts new copies. On the *evict* transition, taken by a replicate miss into a full store, it moves to `ST_DRAIN`, which offers the victim on the memory write port. The *accept* transition, taken when memory raises ready, returns it to `ST_IDLE`. Without an accept the machine stays where it is.

Top module: `drc_cache`

## Requirements
- R1: A replicate of an address not held, while a slot is free, stores the line, and a later recover of that address hits with that data.
- R2: A replicate of an address already held overwrites its data in the same slot. No memory write follows and no other entry is lost. At most one slot ever holds a given address.
- R3: A replicate miss while all ENTRIES slots are valid evicts the entry replicated or updated least recently. Recovers do not change this order. The victim's address and data appear on `wb_addr`/`wb_data` with `wb_valid` high from the next cycle, and the new line takes its slot.
- R4: While a write-back is pending, `rep_ready` is low. `wb_valid`, `wb_addr` and `wb_data` hold until the cycle in which `wb_ready` is high, and `rep_ready` is high again in the cycle after that.
- R5: A remove that matches frees the entry without any memory write, and a later recover of that address misses. A remove that does not match changes nothing.
- R6: `rec_rsp_valid` is high exactly in the cycle after a cycle with `rec_valid`. `rec_rsp_hit` is 1 with the stored data, or 0 with all-zero data.
- R7: A recover of the address held in the pending write-back buffer hits and returns that buffered data.
- R8: In any cycle with `rm_valid` high, `rep_ready` is low, so a replicate offered in that cycle is not taken.
- R9: A recover sees the contents as they were before any replicate or remove taken in the same cycle.
- R10: After reset all slots are empty, `wb_valid` and `rec_rsp_valid` are 0, and `rep_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rep_valid | input | 1 | Offer a dirty line copy |
| rep_ready | output | 1 | Copy is taken when both valid and ready are high |
| rep_addr | input | ADDR_W | Block address of the copy |
| rep_data | input | DATA_W | Line data of the copy |
| rec_valid | input | 1 | Recover request |
| rec_addr | input | ADDR_W | Address to recover |
| rec_rsp_valid | output | 1 | Recover response strobe |
| rec_rsp_hit | output | 1 | 1 when a copy was found |
| rec_rsp_data | output | DATA_W | Copy data, zero on a miss |
| rm_valid | input | 1 | Remove request (L2 wrote back or dropped the block) |
| rm_addr | input | ADDR_W | Address to remove |
| wb_valid | output | 1 | Evicted line awaits memory write |
| wb_ready | input | 1 | Memory accepts the write |
| wb_addr | output | ADDR_W | Address of the evicted line |
| wb_data | output | DATA_W | Data of the evicted line |

## Verification
Two pairs of functions can meet in one cycle. A replicate can arrive together with a remove, where the remove must win and the copy must wait. A recover can arrive together with a replicate or a remove of the same address, where the response must carry the old contents. The bench drives these pairs in directed cycles. It also mixes all four ports at random over a small address range, so that evictions, stalls and late memory accepts overlap. Every cycle is judged against a queue-ordered reference model that applies each cycle's updates only after it has formed that cycle's recover answer.

// File: rtl/drc_pkg.sv
package drc_pkg;
    typedef enum logic {
        ST_IDLE,
        ST_DRAIN
    } drc_state_e;

    typedef enum logic [1:0] {
        LRU_NONE,
        LRU_TOUCH,
        LRU_FREE
    } lru_op_e;
endpackage

// File: rtl/drc_match.sv
module drc_match #(
    parameter int ENTRIES = 64,
    parameter int ADDR_W  = 26,
    parameter int IDX_W   = $clog2(ENTRIES)
) (
    input  logic [ENTRIES-1:0]             valid,
    input  logic [ENTRIES-1:0][ADDR_W-1:0] tags,
    input  logic [ADDR_W-1:0]              key,
    output logic [ENTRIES-1:0]             match,
    output logic                           hit,
    output logic [IDX_W-1:0]               idx
);
    generate
        for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
            assign match[i] = valid[i] && (tags[i] == key);
        end
    endgenerate

    assign hit = |match;

    always_comb begin
        idx = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (match[i]) idx = IDX_W'(i);
        end
    end
endmodule

// File: rtl/drc_store.sv
module drc_store #(
    parameter int ENTRIES = 64,
    parameter int ADDR_W  = 26,
    parameter int DATA_W  = 64,
    parameter int IDX_W   = $clog2(ENTRIES)
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           wr_en,
    input  logic [IDX_W-1:0]               wr_idx,
    input  logic [ADDR_W-1:0]              wr_addr,
    input  logic [DATA_W-1:0]              wr_data,
    input  logic                           clr_en,
    input  logic [IDX_W-1:0]               clr_idx,
    output logic [ENTRIES-1:0]             valid,
    output logic [ENTRIES-1:0][ADDR_W-1:0] tags,
    output logic [ENTRIES-1:0][DATA_W-1:0] data
);
    generate
        for (genvar i = 0; i < ENTRIES; i++) begin : g_slot
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    valid[i] <= 1'b0;
                    tags[i]  <= '0;
                    data[i]  <= '0;
                end else if (wr_en && wr_idx == IDX_W'(i)) begin
                    valid[i] <= 1'b1;
                    tags[i]  <= wr_addr;
                    data[i]  <= wr_data;
                end else if (clr_en && clr_idx == IDX_W'(i)) begin
                    valid[i] <= 1'b0;
                end
            end
        end
    endgenerate

    // R1: a write leaves the slot valid with the written address and data
    a_r1_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> valid[$past(wr_idx)] && tags[$past(wr_idx)] == $past(wr_addr)
                  && data[$past(wr_idx)] == $past(wr_data));

    // R5: a clear without a write to the same slot leaves it invalid
    a_r5_clear_lands: assert property (@(posedge clk) disable iff (!rst_n)
        clr_en && !(wr_en && wr_idx == clr_idx) |=> !valid[$past(clr_idx)]);
endmodule

// File: rtl/drc_lru.sv
module drc_lru
    import drc_pkg::*;
#(
    parameter int ENTRIES = 64,
    parameter int IDX_W   = $clog2(ENTRIES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ENTRIES-1:0] valid,
    input  lru_op_e            op,
    input  logic [IDX_W-1:0]   idx,
    output logic [IDX_W-1:0]   victim_idx,
    output logic [IDX_W-1:0]   free_idx,
    output logic               full
);
    localparam logic [IDX_W:0]   ABSENT_RANK = (IDX_W + 1)'(ENTRIES);
    localparam logic [IDX_W-1:0] OLDEST_RANK = IDX_W'(ENTRIES - 1);

    // rank 0 is the most recent; valid ranks always form 0..count-1
    logic [ENTRIES-1:0][IDX_W-1:0] rank_q;
    logic [ENTRIES-1:0]            oldest;
    logic [IDX_W:0]                pivot;

    assign pivot = valid[idx] ? {1'b0, rank_q[idx]} : ABSENT_RANK;
    assign full  = &valid;

    generate
        for (genvar i = 0; i < ENTRIES; i++) begin : g_rank
            assign oldest[i] = valid[i] && (rank_q[i] == OLDEST_RANK);
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    rank_q[i] <= '0;
                end else begin
                    unique case (op)
                        LRU_TOUCH: begin
                            if (idx == IDX_W'(i))
                                rank_q[i] <= '0;
                            else if (valid[i] && {1'b0, rank_q[i]} < pivot)
                                rank_q[i] <= rank_q[i] + 1'b1;
                        end
                        LRU_FREE: begin
                            if (valid[i] && rank_q[i] > rank_q[idx])
                                rank_q[i] <= rank_q[i] - 1'b1;
                        end
                        default: ;
                    endcase
                end
            end
        end
    endgenerate

    always_comb begin
        victim_idx = '0;
        free_idx   = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (oldest[i]) victim_idx = IDX_W'(i);
            if (!valid[i]) free_idx = IDX_W'(i);
        end
    end

    // R3: a full store always has exactly one oldest entry to evict
    a_r3_one_oldest: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> $countones(oldest) == 1);
endmodule

// File: rtl/drc_cache.sv
module drc_cache
    import drc_pkg::*;
#(
    parameter int ENTRIES = 64,
    parameter int ADDR_W  = 26,
    parameter int DATA_W  = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rep_valid,
    output logic              rep_ready,
    input  logic [ADDR_W-1:0] rep_addr,
    input  logic [DATA_W-1:0] rep_data,
    input  logic              rec_valid,
    input  logic [ADDR_W-1:0] rec_addr,
    output logic              rec_rsp_valid,
    output logic              rec_rsp_hit,
    output logic [DATA_W-1:0] rec_rsp_data,
    input  logic              rm_valid,
    input  logic [ADDR_W-1:0] rm_addr,
    output logic              wb_valid,
    input  logic              wb_ready,
    output logic [ADDR_W-1:0] wb_addr,
    output logic [DATA_W-1:0] wb_data
);
    localparam int IDX_W = $clog2(ENTRIES);

    drc_state_e state_q, state_d;

    logic [ENTRIES-1:0]             ent_valid;
    logic [ENTRIES-1:0][ADDR_W-1:0] ent_tags;
    logic [ENTRIES-1:0][DATA_W-1:0] ent_data;

    logic [ENTRIES-1:0] rep_match, rec_match, rm_match;
    logic               rep_hit, rec_hit, rm_hit;
    logic [IDX_W-1:0]   rep_idx, rec_idx, rm_idx;
    logic [IDX_W-1:0]   victim_idx, free_idx, wr_idx, lru_idx;
    logic               full, rep_fire, evict, clr_en, buf_hit;
    lru_op_e            lru_op;

    logic [ADDR_W-1:0]  wb_addr_q;
    logic [DATA_W-1:0]  wb_data_q;
    logic               rsp_valid_q, rsp_hit_q;
    logic [DATA_W-1:0]  rsp_data_q;

    drc_match #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_rep_match (
        .valid(ent_valid), .tags(ent_tags), .key(rep_addr),
        .match(rep_match), .hit(rep_hit), .idx(rep_idx));

    drc_match #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_rec_match (
        .valid(ent_valid), .tags(ent_tags), .key(rec_addr),
        .match(rec_match), .hit(rec_hit), .idx(rec_idx));

    drc_match #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_rm_match (
        .valid(ent_valid), .tags(ent_tags), .key(rm_addr),
        .match(rm_match), .hit(rm_hit), .idx(rm_idx));

    drc_lru #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_lru (
        .clk(clk), .rst_n(rst_n), .valid(ent_valid), .op(lru_op), .idx(lru_idx),
        .victim_idx(victim_idx), .free_idx(free_idx), .full(full));

    drc_store #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_store (
        .clk(clk), .rst_n(rst_n),
        .wr_en(rep_fire), .wr_idx(wr_idx), .wr_addr(rep_addr), .wr_data(rep_data),
        .clr_en(clr_en), .clr_idx(rm_idx),
        .valid(ent_valid), .tags(ent_tags), .data(ent_data));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // transitions: evict (IDLE->DRAIN), accept (DRAIN->IDLE)
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (evict)    state_d = ST_DRAIN;
            ST_DRAIN: if (wb_ready) state_d = ST_IDLE;
            default:                state_d = ST_IDLE;
        endcase
    end

    // outputs and per-cycle controls
    always_comb begin
        rep_ready = 1'b0;
        wb_valid  = 1'b0;
        unique case (state_q)
            ST_IDLE:  rep_ready = !rm_valid;
            ST_DRAIN: wb_valid  = 1'b1;
            default: ;
        endcase
        rep_fire = rep_valid && rep_ready;
        evict    = rep_fire && !rep_hit && full;
        clr_en   = rm_valid && rm_hit;
        if (rep_hit)   wr_idx = rep_idx;
        else if (full) wr_idx = victim_idx;
        else           wr_idx = free_idx;
        if (clr_en) begin
            lru_op  = LRU_FREE;
            lru_idx = rm_idx;
        end else if (rep_fire) begin
            lru_op  = LRU_TOUCH;
            lru_idx = wr_idx;
        end else begin
            lru_op  = LRU_NONE;
            lru_idx = '0;
        end
        buf_hit = (state_q == ST_DRAIN) && (wb_addr_q == rec_addr);
    end

    // pending write-back buffer
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wb_addr_q <= '0;
            wb_data_q <= '0;
        end else if (evict) begin
            wb_addr_q <= ent_tags[victim_idx];
            wb_data_q <= ent_data[victim_idx];
        end
    end

    assign wb_addr = wb_addr_q;
    assign wb_data = wb_data_q;

    // recover response, one cycle after the request
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_valid_q <= 1'b0;
            rsp_hit_q   <= 1'b0;
            rsp_data_q  <= '0;
        end else begin
            rsp_valid_q <= rec_valid;
            rsp_hit_q   <= rec_valid && (rec_hit || buf_hit);
            if (rec_valid && rec_hit)      rsp_data_q <= ent_data[rec_idx];
            else if (rec_valid && buf_hit) rsp_data_q <= wb_data_q;
            else                           rsp_data_q <= '0;
        end
    end

    assign rec_rsp_valid = rsp_valid_q;
    assign rec_rsp_hit   = rsp_hit_q;
    assign rec_rsp_data  = rsp_data_q;

    // R2: never two slots holding the same address
    a_r2_single_copy: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(rec_match) && $onehot0(rep_match) && $onehot0(rm_match));

    // R3: an eviction raises the memory write request next cycle
    a_r3_evict_request: assert property (@(posedge clk) disable iff (!rst_n)
        rep_valid && rep_ready && !rep_hit && full |=> wb_valid);

    // R4: the memory write request holds its payload until taken
    a_r4_wb_hold: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid && !wb_ready |=> wb_valid && $stable(wb_addr) && $stable(wb_data));

    // R4: no copy is taken while a write-back waits
    a_r4_no_insert_draining: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid |-> !(rep_valid && rep_ready));

    // R6: response strobe follows each request by one cycle
    a_r6_rsp_timing: assert property (@(posedge clk) disable iff (!rst_n)
        rec_valid |=> rec_rsp_valid);
    a_r6_no_spurious_rsp: assert property (@(posedge clk) disable iff (!rst_n)
        !rec_valid |=> !rec_rsp_valid);

    // R6: a miss carries zero data
    a_r6_miss_zero: assert property (@(posedge clk) disable iff (!rst_n)
        rec_rsp_valid && !rec_rsp_hit |-> rec_rsp_data == '0);
endmodule

// File: tb/drc_cache_tb_top.sv
`timescale 1ns/1ps
module drc_cache_tb_top;
    localparam int N  = 64;
    localparam int AW = 26;
    localparam int DW = 64;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          rep_valid = 1'b0, rep_ready;
    logic [AW-1:0] rep_addr = '0;
    logic [DW-1:0] rep_data = '0;
    logic          rec_valid = 1'b0;
    logic [AW-1:0] rec_addr = '0;
    logic          rec_rsp_valid, rec_rsp_hit;
    logic [DW-1:0] rec_rsp_data;
    logic          rm_valid = 1'b0;
    logic [AW-1:0] rm_addr = '0;
    logic          wb_valid, wb_ready = 1'b0;
    logic [AW-1:0] wb_addr;
    logic [DW-1:0] wb_data;

    always #4 clk = ~clk;

    drc_cache #(.ENTRIES(N), .ADDR_W(AW), .DATA_W(DW)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .rep_valid(rep_valid), .rep_ready(rep_ready), .rep_addr(rep_addr), .rep_data(rep_data),
        .rec_valid(rec_valid), .rec_addr(rec_addr),
        .rec_rsp_valid(rec_rsp_valid), .rec_rsp_hit(rec_rsp_hit), .rec_rsp_data(rec_rsp_data),
        .rm_valid(rm_valid), .rm_addr(rm_addr),
        .wb_valid(wb_valid), .wb_ready(wb_ready), .wb_addr(wb_addr), .wb_data(wb_data));

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;

    // reference model: queue index 0 is the most recent entry
    logic [AW-1:0] m_order[$];
    logic [DW-1:0] m_dat[logic [AW-1:0]];
    bit            m_drain = 0;
    logic [AW-1:0] m_wb_a = '0;
    logic [DW-1:0] m_wb_d = '0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 190000) begin
            n_fail++;
            $display("FAIL watchdog: actual %0d expected below 190000", cyc);
            summary();
        end
    end

    task automatic drop(input logic [AW-1:0] a);
        for (int k = 0; k < m_order.size(); k++) begin
            if (m_order[k] == a) begin
                m_order.delete(k);
                break;
            end
        end
    endtask

    // one clock cycle: drive at the falling edge, judge at the next falling edge
    task automatic step(input bit rv, input logic [AW-1:0] ra, input logic [DW-1:0] rd,
                        input bit cv, input logic [AW-1:0] ca,
                        input bit mv, input logic [AW-1:0] ma,
                        input bit wr, input string tag);
        bit            exp_ready, exp_hit;
        logic [DW-1:0] exp_d;
        rep_valid = rv; rep_addr = ra; rep_data = rd;
        rec_valid = cv; rec_addr = ca;
        rm_valid  = mv; rm_addr  = ma;
        wb_ready  = wr;
        #1;
        exp_ready = !m_drain && !mv;
        chk(rep_ready == exp_ready, {tag, " R4 R8"}, "rep_ready", DW'(rep_ready), DW'(exp_ready));
        // R9: the answer is formed from the state before this cycle's updates
        exp_hit = 0;
        exp_d   = '0;
        if (m_dat.exists(ca)) begin
            exp_hit = 1; exp_d = m_dat[ca];
        end else if (m_drain && m_wb_a == ca) begin
            exp_hit = 1; exp_d = m_wb_d;
        end
        if (m_drain && wr) m_drain = 0;
        if (mv && m_dat.exists(ma)) begin
            m_dat.delete(ma);
            drop(ma);
        end
        if (rv && exp_ready) begin
            if (m_dat.exists(ra)) begin
                drop(ra);
            end else if (m_order.size() == N) begin
                m_wb_a = m_order.pop_back();
                m_wb_d = m_dat[m_wb_a];
                m_dat.delete(m_wb_a);
                m_drain = 1;
            end
            m_order.push_front(ra);
            m_dat[ra] = rd;
        end
        @(posedge clk);
        @(negedge clk);
        chk(rec_rsp_valid == cv, {tag, " R6"}, "rec_rsp_valid", DW'(rec_rsp_valid), DW'(cv));
        if (cv) begin
            chk(rec_rsp_hit == exp_hit, {tag, " R6 R9"}, "rec_rsp_hit", DW'(rec_rsp_hit), DW'(exp_hit));
            chk(rec_rsp_data == exp_d, {tag, " R6 R9"}, "rec_rsp_data", rec_rsp_data, exp_d);
        end
        chk(wb_valid == m_drain, {tag, " R3 R4"}, "wb_valid", DW'(wb_valid), DW'(m_drain));
        if (m_drain) begin
            chk(wb_addr == m_wb_a, {tag, " R3"}, "wb_addr", DW'(wb_addr), DW'(m_wb_a));
            chk(wb_data == m_wb_d, {tag, " R3"}, "wb_data", wb_data, m_wb_d);
        end
    endtask

    task automatic idle(input bit wr, input string tag);
        step(0, '0, '0, 0, '0, 0, '0, wr, tag);
    endtask

    task automatic recover(input logic [AW-1:0] a, input string tag);
        step(0, '0, '0, 1, a, 0, '0, 1, tag);
    endtask

    task automatic replicate(input logic [AW-1:0] a, input logic [DW-1:0] d, input string tag);
        step(1, a, d, 0, '0, 0, '0, 1, tag);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R10: reset state
        chk(wb_valid == 0, "R10", "wb_valid", DW'(wb_valid), '0);
        chk(rec_rsp_valid == 0, "R10", "rec_rsp_valid", DW'(rec_rsp_valid), '0);
        chk(rep_ready == 1, "R10", "rep_ready", DW'(rep_ready), 1);
        @(negedge clk);
        recover(26'h5, "R10 empty");

        // R1: store into a free slot, then recover it
        replicate(26'h10, 64'hA1A1_0000_0000_0001, "R1");
        recover(26'h10, "R1");
        // R2: in-place update
        replicate(26'h10, 64'hB2B2_0000_0000_0002, "R2");
        recover(26'h10, "R2");
        // R9: recover and update of the same address in one cycle
        step(1, 26'h10, 64'hC3C3_0000_0000_0003, 1, 26'h10, 0, '0, 1, "R9");
        recover(26'h10, "R9 after");
        // R8: remove and replicate together; the copy is not taken
        step(1, 26'h11, 64'h1111, 1, 26'h10, 1, 26'h10, 1, "R8");
        recover(26'h11, "R8 not taken");
        // R5: removed entry misses; a remove of an absent address changes nothing
        recover(26'h10, "R5");
        replicate(26'h12, 64'h1212, "R5 setup");
        step(0, '0, '0, 0, '0, 1, 26'h99, 1, "R5 miss");
        recover(26'h12, "R5 unaffected");
        step(0, '0, '0, 0, '0, 1, 26'h12, 1, "R5");

        // R3: fill every slot, refresh the first, then overflow
        for (int i = 0; i < N; i++)
            replicate(AW'(100 + i), DW'(64'hD000 + i), "R3 fill");
        replicate(26'd100, 64'hEEEE, "R3 refresh");
        recover(26'd101, "R3 recover keeps order");
        step(1, 26'd200, 64'hF200, 0, '0, 0, '0, 0, "R3 evict");
        // R4: stalled while memory does not accept
        step(1, 26'd201, 64'hF201, 0, '0, 0, '0, 0, "R4 stall");
        // R7: recover from the pending buffer
        step(0, '0, '0, 1, 26'd101, 0, '0, 0, "R7");
        step(0, '0, '0, 1, 26'd100, 0, '0, 1, "R4 accept");
        replicate(26'd201, 64'hF201, "R4 resume");
        idle(1, "R4 drain");
        recover(26'd101, "R3 gone");

        // mixed traffic over a small address range
        for (int t = 0; t < 6000; t++) begin
            step($urandom_range(0, 2) != 0, AW'($urandom_range(0, 95)), {$urandom, $urandom},
                 $urandom_range(0, 1) == 1, AW'($urandom_range(0, 95)),
                 $urandom_range(0, 5) == 0, AW'($urandom_range(0, 95)),
                 $urandom_range(0, 2) != 0, "R3 mix");
        end
        for (int t = 0; t < 4; t++) idle(1, "R4 final");
        summary();
    end
endmodule